// File: doc/BRIEF.md
# Mixed Fixed/Programmable Interrupt Priority Resolver

This block reduces a vector of pending interrupt requests to one request for the processor core. It also gives that request's priority level and its source index, and the core uses the index as the vector number. Three sources have levels wired into the logic. Index 0 is the non-maskable source at level 16. Index 1 is the break source at level 15. Index 2 is the debug-port source at level 15. Every other source, at indices 3 upward, takes its level from a 4-bit register that software writes through a simple select/data/enable port. A 4-bit register cannot hold 16, so no programmable source can ever reach the non-maskable level.

In each cycle the block finds the pending sources whose level is strictly above the current CPU mask level. The non-maskable source is always eligible. Among the eligible sources the block picks the highest level, and on a tie it picks the lowest index. It registers the result, so the outputs describe the inputs sampled at the previous rising clock edge. Vector fetch, context saving and exception return are handled elsewhere.

Top module: `irq_pri_resolver`

## Requirements
- R1: After reset, accept_o, level_o and src_o are 0 and every programmable level register holds 0, so a lone programmable request at mask 0 is not accepted.
- R2: A request on index 0 is presented at level 16 with src_o = 0 whatever the value of mask_i, including mask 15.
- R3: Indices 1 and 2 have a fixed level 15. They are accepted when mask_i is 14 or lower and refused at mask 15.
- R4: Programmable source k (index 3+k) uses register k. A write with cfg_we_i = 1 and cfg_sel_i = k < N_PROG stores cfg_data_i. A write with cfg_sel_i >= N_PROG changes no register. A programmable level is never above 15.
- R5: A maskable request is accepted only when its level is strictly greater than mask_i. A level of 0 is never accepted.
- R6: Among eligible requests, the one with the highest level is presented.
- R7: When eligible requests share the highest level, the lowest source index is presented.
- R8: The outputs reflect req_i and mask_i sampled at the previous rising edge. A level write takes part in resolution from the edge after the one that stores it.
- R9: When no request is eligible, accept_o = 0, level_o = 0 and src_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_PROG+3 | Request lines; bit i is source index i |
| cfg_we_i | input | 1 | Level register write enable |
| cfg_sel_i | input | $clog2(N_PROG+1) | Programmable register number |
| cfg_data_i | input | 4 | Level value to store |
| mask_i | input | 4 | Current CPU mask level |
| accept_o | output | 1 | A request is presented to the core |
| level_o | output | 5 | Level of the presented request (0..16) |
| src_o | output | $clog2(N_PROG+3) | Index (vector number) of the presented request |

## Verification
The bench first aims at the mask comparison at its edge, where the level equals the mask or the mask is one below it. A design that compared with "greater or equal" would accept at equal level, and a design that let level 0 through would interrupt from freshly reset registers. Ties are checked between a fixed level-15 source and a programmable level-15 source, and between two programmable sources. A reversed scan would give the higher index. Further checks cover the non-maskable source at mask 15, a write to an out-of-range register number (which a design that truncates the select would alias onto register 0), and a level write made while a request is held, which shows whether the old level stays in use for exactly one more edge.

// File: rtl/irq_pri_pkg.sv
package irq_pri_pkg;
   localparam int LVL_W     = 5;   // levels 0..16
   localparam int MASK_W    = 4;
   localparam int PRIO_W    = 4;   // programmable level width
   localparam int NUM_FIXED = 3;   // indices 0..2 are hard-wired
   localparam int NMI_IDX   = 0;
   localparam logic [LVL_W-1:0] LVL_NMI = LVL_W'(16);
   localparam logic [LVL_W-1:0] LVL_DBG = LVL_W'(15);

   typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_pri_regs.sv
module irq_pri_regs
   import irq_pri_pkg::*;
#(
   parameter int N_PROG = 8,
   localparam int SEL_W = $clog2(N_PROG + 1)
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic                         we_i,
   input  logic [SEL_W-1:0]             sel_i,
   input  logic [PRIO_W-1:0]            data_i,
   output logic [N_PROG-1:0][PRIO_W-1:0] prio_o
);
   if (N_PROG < 1) begin : g_bad_nprog
      $error("irq_pri_regs: N_PROG must be at least 1");
   end

   logic [N_PROG-1:0][PRIO_W-1:0] prio_q;

   for (genvar k = 0; k < N_PROG; k++) begin : g_reg
      logic hit;
      assign hit = we_i && (sel_i == SEL_W'(k));
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            prio_q[k] <= '0;
         end else if (hit) begin
            prio_q[k] <= data_i;
         end
      end
   end

   assign prio_o = prio_q;

   // A valid write is visible in the addressed register one edge later.
   assert_write_store_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(we_i) && ($past(sel_i) < SEL_W'(N_PROG)))
         |-> (prio_q[$past(sel_i)] == $past(data_i)));

   // An out-of-range select leaves every register unchanged.
   assert_oob_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(we_i) && ($past(sel_i) >= SEL_W'(N_PROG)))
         |-> (prio_q == $past(prio_q)));
endmodule

// File: rtl/irq_pri_levels.sv
module irq_pri_levels
   import irq_pri_pkg::*;
#(
   parameter int N_PROG = 8,
   localparam int N_SRC = N_PROG + NUM_FIXED
) (
   input  logic [N_PROG-1:0][PRIO_W-1:0] prio_i,
   output logic [N_SRC-1:0][LVL_W-1:0]   lvl_o
);
   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      if (i == NMI_IDX) begin : g_nmi
         assign lvl_o[i] = LVL_NMI;
      end else if (i < NUM_FIXED) begin : g_dbg
         assign lvl_o[i] = LVL_DBG;
      end else begin : g_prog
         // Zero-extended 4-bit value: 16 is unreachable.
         assign lvl_o[i] = {1'b0, prio_i[i-NUM_FIXED]};
      end
   end
endmodule

// File: rtl/irq_pri_select.sv
module irq_pri_select
   import irq_pri_pkg::*;
#(
   parameter int N_PROG = 8,
   localparam int N_SRC = N_PROG + NUM_FIXED,
   localparam int IDX_W = $clog2(N_SRC)
) (
   input  logic [N_SRC-1:0]            req_i,
   input  logic [N_SRC-1:0][LVL_W-1:0] lvl_i,
   input  logic [MASK_W-1:0]           mask_i,
   output logic                        found_o,
   output lvl_t                        lvl_o,
   output logic [IDX_W-1:0]            idx_o
);
   logic [N_SRC-1:0] elig;

   for (genvar i = 0; i < N_SRC; i++) begin : g_elig
      if (i == NMI_IDX) begin : g_nm
         assign elig[i] = req_i[i];
      end else begin : g_mk
         assign elig[i] = req_i[i] && (lvl_i[i] > {1'b0, mask_i});
      end
   end

   // Scan from the top index down; ">=" lets a lower index take a tie.
   always_comb begin
      found_o = 1'b0;
      lvl_o   = '0;
      idx_o   = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (elig[i] && (!found_o || (lvl_i[i] >= lvl_o))) begin
            found_o = 1'b1;
            lvl_o   = lvl_i[i];
            idx_o   = IDX_W'(i);
         end
      end
   end

   // The chosen source is one that was eligible.
   always_comb begin
      assert_pick_eligible_R6: assert (!found_o || elig[idx_o]);
      assert_found_any_R9:     assert (found_o == (|elig));
   end
endmodule

// File: rtl/irq_pri_resolver.sv
module irq_pri_resolver
   import irq_pri_pkg::*;
#(
   parameter int N_PROG = 8,
   localparam int N_SRC = N_PROG + NUM_FIXED,
   localparam int IDX_W = $clog2(N_SRC),
   localparam int SEL_W = $clog2(N_PROG + 1)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [N_SRC-1:0]   req_i,
   input  logic               cfg_we_i,
   input  logic [SEL_W-1:0]   cfg_sel_i,
   input  logic [PRIO_W-1:0]  cfg_data_i,
   input  logic [MASK_W-1:0]  mask_i,
   output logic               accept_o,
   output logic [LVL_W-1:0]   level_o,
   output logic [IDX_W-1:0]   src_o
);
   if (N_PROG < 1 || N_SRC > 64) begin : g_bad_size
      $error("irq_pri_resolver: N_PROG out of supported range");
   end

   logic [N_PROG-1:0][PRIO_W-1:0] prio;
   logic [N_SRC-1:0][LVL_W-1:0]   lvl;
   logic                          found;
   lvl_t                          win_lvl;
   logic [IDX_W-1:0]              win_idx;

   irq_pri_regs #(.N_PROG(N_PROG)) i_regs (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (cfg_we_i),
      .sel_i  (cfg_sel_i),
      .data_i (cfg_data_i),
      .prio_o (prio)
   );

   irq_pri_levels #(.N_PROG(N_PROG)) i_levels (
      .prio_i (prio),
      .lvl_o  (lvl)
   );

   irq_pri_select #(.N_PROG(N_PROG)) i_select (
      .req_i   (req_i),
      .lvl_i   (lvl),
      .mask_i  (mask_i),
      .found_o (found),
      .lvl_o   (win_lvl),
      .idx_o   (win_idx)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         accept_o <= 1'b0;
         level_o  <= '0;
         src_o    <= '0;
      end else begin
         accept_o <= found;
         level_o  <= found ? win_lvl : '0;
         src_o    <= found ? win_idx : '0;
      end
   end

   assert_nmi_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(req_i[NMI_IDX]))
         |-> (accept_o && (level_o == LVL_NMI) && (src_o == IDX_W'(NMI_IDX))));

   assert_fixed_lvl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept_o && ((src_o == IDX_W'(1)) || (src_o == IDX_W'(2))))
         |-> (level_o == LVL_DBG));

   assert_prog_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept_o && (src_o >= IDX_W'(NUM_FIXED))) |-> (level_o <= LVL_DBG));

   assert_above_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && accept_o && (src_o != IDX_W'(NMI_IDX)))
         |-> (level_o > {1'b0, $past(mask_i)}));

   assert_level_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accept_o |-> (level_o != '0));

   assert_req_pending_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && accept_o) |-> ((($past(req_i) >> src_o) & N_SRC'(1)) != '0));

   assert_idle_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !accept_o |-> ((level_o == '0) && (src_o == '0)));
endmodule

// File: tb/test_irq_pri_resolver.sv
module test_irq_pri_resolver;
   localparam int N_PROG = 8;
   localparam int N_SRC  = N_PROG + 3;
   localparam int IDX_W  = $clog2(N_SRC);
   localparam int SEL_W  = $clog2(N_PROG + 1);
   localparam int VW     = N_SRC + 4 + 1 + 5 + IDX_W;
   localparam int NV     = 14;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [N_SRC-1:0] req = '0;
   logic             we = 1'b0;
   logic [SEL_W-1:0] sel = '0;
   logic [3:0]       wdata = '0;
   logic [3:0]       mask = '0;
   logic             acc;
   logic [4:0]       lvl;
   logic [IDX_W-1:0] src;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #2 clk = ~clk;

   irq_pri_resolver #(.N_PROG(N_PROG)) i_irq_pri_resolver (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .cfg_we_i(we),
      .cfg_sel_i(sel), .cfg_data_i(wdata), .mask_i(mask),
      .accept_o(acc), .level_o(lvl), .src_o(src)
   );

   // Programmable levels used by the table: index 3+k gets PL[k].
   localparam logic [3:0] PL [N_PROG] = '{4'd5, 4'd9, 4'd9, 4'd0, 4'd15, 4'd3, 4'd12, 4'd1};

   // {req, mask, exp_accept, exp_level, exp_src}
   localparam logic [VW-1:0] VEC [NV] = '{
      {11'b000_0000_1000, 4'd0,  1'b1, 5'd5,  4'd3},  // R5 above mask
      {11'b000_0000_1000, 4'd5,  1'b0, 5'd0,  4'd0},  // R5 equal refused
      {11'b000_0000_1000, 4'd4,  1'b1, 5'd5,  4'd3},  // R5 one below
      {11'b000_0011_0000, 4'd0,  1'b1, 5'd9,  4'd4},  // R7 prog tie
      {11'b000_0100_0000, 4'd0,  1'b0, 5'd0,  4'd0},  // R5 level 0
      {11'b000_1000_0010, 4'd0,  1'b1, 5'd15, 4'd1},  // R7 fixed vs prog tie
      {11'b000_0000_0110, 4'd14, 1'b1, 5'd15, 4'd1},  // R3 mask 14
      {11'b000_0000_0010, 4'd15, 1'b0, 5'd0,  4'd0},  // R3 mask 15
      {11'b000_1000_0001, 4'd15, 1'b1, 5'd16, 4'd0},  // R2 mask 15
      {11'b111_1111_1111, 4'd0,  1'b1, 5'd16, 4'd0},  // R2 all pending
      {11'b111_1111_1110, 4'd0,  1'b1, 5'd15, 4'd1},  // R6 no nmi
      {11'b111_0000_1000, 4'd0,  1'b1, 5'd12, 4'd9},  // R6 highest
      {11'b111_0000_1000, 4'd12, 1'b0, 5'd0,  4'd0},  // R9 all masked
      {11'b101_0000_0000, 4'd2,  1'b1, 5'd3,  4'd8}   // R6 low levels
   };

   task automatic check(string tag, logic a, logic [4:0] l, logic [IDX_W-1:0] s,
                        logic ea, logic [4:0] el, logic [IDX_W-1:0] es);
      checks++;
      if (a !== ea || l !== el || s !== es) begin
         failures++;
         $display("FAIL %s: actual acc=%0b lvl=%0d src=%0d expected acc=%0b lvl=%0d src=%0d",
                  tag, a, l, s, ea, el, es);
      end
   endtask

   task automatic write_reg(int k, logic [3:0] d);
      @(negedge clk);
      we = 1'b1; sel = SEL_W'(k); wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   // Drive at negedge, sample shortly after the next rising edge.
   task automatic apply(logic [N_SRC-1:0] r, logic [3:0] m);
      @(negedge clk);
      req = r; mask = m;
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset outputs", acc, lvl, src, 1'b0, 5'd0, '0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: registers reset to 0, so programmable source is not accepted.
      apply(11'b000_0000_1000, 4'd0);
      check("R1 prog disabled after reset", acc, lvl, src, 1'b0, 5'd0, '0);
      apply(11'b111_1111_1000, 4'd0);
      check("R1 all prog disabled", acc, lvl, src, 1'b0, 5'd0, '0);

      for (int k = 0; k < N_PROG; k++) write_reg(k, PL[k]);

      for (int v = 0; v < NV; v++) begin
         logic [VW-1:0] e;
         e = VEC[v];
         apply(e[VW-1 -: N_SRC], e[IDX_W+5+1 +: 4]);
         check($sformatf("vec%0d R5 R6 R7", v), acc, lvl, src,
               e[IDX_W+5], e[IDX_W +: 5], e[IDX_W-1:0]);
      end

      // R4: out-of-range select must not alias onto register 0.
      apply('0, 4'd0);
      write_reg(8, 4'd15);
      write_reg(15, 4'd15);
      apply(11'b000_0000_1000, 4'd0);
      check("R4 out-of-range write ignored", acc, lvl, src, 1'b1, 5'd5, 4'd3);

      // R4: max programmable level stays below non-maskable.
      write_reg(0, 4'd15);
      apply(11'b000_0000_1001, 4'd0);
      check("R4 prog 15 under nmi", acc, lvl, src, 1'b1, 5'd16, 4'd0);
      apply(11'b000_0000_1000, 4'd14);
      check("R4 prog 15 stored", acc, lvl, src, 1'b1, 5'd15, 4'd3);

      // R8: outputs lag inputs by one edge.
      apply('0, 4'd0);
      @(negedge clk);
      req = 11'b000_0000_0100; mask = 4'd0;
      #1;
      check("R8 before edge", acc, lvl, src, 1'b0, 5'd0, '0);
      @(posedge clk); #1;
      check("R8 after edge", acc, lvl, src, 1'b1, 5'd15, 4'd2);

      // R8: write while request held; old level used for the storing edge.
      apply(11'b000_0000_1000, 4'd0);
      check("R8 held old level", acc, lvl, src, 1'b1, 5'd15, 4'd3);
      @(negedge clk);
      we = 1'b1; sel = '0; wdata = 4'd7;
      @(posedge clk); #1;
      check("R8 storing edge old level", acc, lvl, src, 1'b1, 5'd15, 4'd3);
      @(negedge clk);
      we = 1'b0;
      @(posedge clk); #1;
      check("R8 new level next edge", acc, lvl, src, 1'b1, 5'd7, 4'd3);

      // R9: dropping all requests returns outputs to zero.
      apply('0, 4'd0);
      check("R9 idle", acc, lvl, src, 1'b0, 5'd0, '0);

      // R1: mid-run reset clears registers again.
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      apply(11'b000_0000_1000, 4'd0);
      check("R1 reset clears levels", acc, lvl, src, 1'b0, 5'd0, '0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule